// File: doc/BRIEF.md
# Counting-Network Index Allocator

This block is a fetch-and-increment unit that hands out unique, gap-free integer indices to many requesters at once without a single central counter. A request is a token that enters on any of `W` request ports. It passes through a pipelined bitonic counting network built from two-input toggle balancers. It leaves on one of `W` output wires, and each wire ends in its own striped counter: wire `i` issues `i`, `i+W`, `i+2W`, and so on. The response carries the issued index together with the requester tag that travelled with the token.

Each balancer holds one toggle bit. A lone token takes the output selected by the bit and flips it. Two tokens that reach the same balancer in the same cycle take one output each, and the bit stays as it was. The network for width `2k` is two width-`k` networks followed by a width-`2k` merger. The merger routes the even outputs of one half with the odd outputs of the other into one half-width merger, routes the rest into a second, and closes with a row of balancers that pair like-numbered outputs. Every balancer stage is one register stage, so a token spends `log2(W)*(log2(W)+1)/2` advancing cycles in the network (6 for `W = 8`).

Back-pressure rules: all request ports share one `req_ready`, and all response wires share one `rsp_ready`. The pipeline advances on a cycle only when `rsp_ready` is high or no response is valid, and `req_ready` equals that advance condition, combinationally from `rsp_ready`. A request transfers when its `req_valid` is high and `req_ready` is high. On an advancing cycle, every response wire showing `rsp_valid` transfers together. While responses are valid and `rsp_ready` is low, all response outputs hold and no request is taken.

Top module: `cnet_index_alloc`

## Requirements
- R1: After reset no response is valid, and the first token sent through an idle network from reset receives index 0.
- R2: `req_ready` is high exactly when `rsp_ready` is high or no `rsp_valid` bit is set, and every request port with `req_valid` high transfers on such a cycle.
- R3: The tokens accepted on one advancing cycle appear as responses, with their requester tags, exactly `log2(W)*(log2(W)+1)/2` advancing cycles later, all on the same cycle; no token is lost or duplicated in between.
- R4: A response on wire `i` carries an index equal to `i` modulo `W`. Successive indices on wire `i` are `i`, `i+W`, `i+2W`, and so on.
- R5: No index is ever issued twice.
- R6: Whenever the network holds no tokens, the indices issued so far are exactly 0 to N-1, where N is the number of tokens accepted. Equivalently, the exit counts per wire have the step property: no wire has fewer exits than a higher-numbered wire, and no two wires differ by more than one.
- R7: When tokens are sent one at a time, each draining before the next, the k-th token receives index k, whichever request port it uses.
- R8: While any `rsp_valid` bit is set and `rsp_ready` is low, `rsp_valid`, `rsp_id` and `rsp_value` keep their values on the next cycle.
- R9: Two tokens reaching one balancer in the same cycle leave on different outputs and leave its toggle bit unchanged. A lone token flips the bit and leaves on the upper output when the bit was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | W | One request token per port |
| req_id | input | W*TAG_W | Requester tag per port, port `i` in bits `[i*TAG_W +: TAG_W]` |
| req_ready | output | 1 | Shared ready for all request ports |
| rsp_valid | output | W | Response valid per output wire |
| rsp_id | output | W*TAG_W | Tag of the token leaving on each wire |
| rsp_value | output | W*VAL_W | Issued index per wire, wire `i` in bits `[i*VAL_W +: VAL_W]` |
| rsp_ready | input | 1 | Shared ready for all response wires |

## Verification
A token accepted on an advancing cycle is due at the response ports after exactly six further advancing edges (for W = 8). Stalled cycles do not count toward that number. The bench drives inputs on the falling edge and samples one time unit later. It keeps a queue of tag groups that is pushed and popped only on cycles it predicts will advance, so the group at the head of the queue is the one that must be visible at the response ports on that cycle. After each phase the bench holds `rsp_ready` high for more than six advancing cycles and then checks that the issued set is exactly 0 to N-1. In the one-at-a-time phase it drains after every token and compares the index with the token count.

// File: rtl/cnet_pkg.sv
package cnet_pkg;
  parameter int TAG_W = 4;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
  } tok_t;

  // balancer stages of a bitonic counting network of width w
  function automatic int net_depth(input int w);
    int lg;
    lg = $clog2(w);
    return lg * (lg + 1) / 2;
  endfunction
endpackage

// File: rtl/cnet_balancer.sv
module cnet_balancer
  import cnet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  tok_t in_a,
  input  tok_t in_b,
  output tok_t out_hi,
  output tok_t out_lo
);
  logic toggle;
  tok_t nx_hi, nx_lo;
  logic nx_tg;

  always_comb begin
    nx_hi = '0;
    nx_lo = '0;
    nx_tg = toggle;
    if (in_a.vld && in_b.vld) begin
      nx_hi = in_a;
      nx_lo = in_b;
    end else if (in_a.vld || in_b.vld) begin
      nx_tg = ~toggle;
      if (!toggle) nx_hi = in_a.vld ? in_a : in_b;
      else         nx_lo = in_a.vld ? in_a : in_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle <= 1'b0;
      out_hi <= '0;
      out_lo <= '0;
    end else if (adv) begin
      toggle <= nx_tg;
      out_hi <= nx_hi;
      out_lo <= nx_lo;
    end
  end

  // R9
  pair_keeps_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_a.vld && in_b.vld) |=> ($stable(toggle) && out_hi.vld && out_lo.vld))
    else $error("pair at balancer changed toggle");

  // R9
  lone_flips_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (in_a.vld ^ in_b.vld)) |=> ((toggle != $past(toggle)) && (out_hi.vld == !$past(toggle))
                                        && (out_lo.vld == $past(toggle))))
    else $error("lone token misrouted");

  // R3
  token_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ($countones({out_hi.vld, out_lo.vld}) == $countones({$past(in_a.vld), $past(in_b.vld)})))
    else $error("balancer lost or made a token");
endmodule

// File: rtl/cnet_merger.sv
module cnet_merger
  import cnet_pkg::*;
#(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  tok_t [K-1:0]   in_t,
  output tok_t [K-1:0]   out_t
);
  localparam int H = K / 2;
  localparam int Q = K / 4;

  generate
    if (K == 2) begin : g_leaf
      cnet_balancer u_bal (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_a(in_t[0]), .in_b(in_t[1]),
        .out_hi(out_t[0]), .out_lo(out_t[1])
      );
    end else begin : g_split
      tok_t [H-1:0] s0_in, s1_in, s0_out, s1_out;
      // even wires of upper half with odd wires of lower half, and the rest
      for (genvar j = 0; j < Q; j++) begin : g_route
        assign s0_in[j]     = in_t[2*j];
        assign s0_in[Q+j]   = in_t[H+2*j+1];
        assign s1_in[j]     = in_t[2*j+1];
        assign s1_in[Q+j]   = in_t[H+2*j];
      end
      cnet_merger #(.K(H)) u_m0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_t(s0_in), .out_t(s0_out)
      );
      cnet_merger #(.K(H)) u_m1 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_t(s1_in), .out_t(s1_out)
      );
      for (genvar i = 0; i < H; i++) begin : g_join
        cnet_balancer u_bal (
          .clk(clk), .rst_n(rst_n), .adv(adv),
          .in_a(s0_out[i]), .in_b(s1_out[i]),
          .out_hi(out_t[2*i]), .out_lo(out_t[2*i+1])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/cnet_bitonic.sv
module cnet_bitonic
  import cnet_pkg::*;
#(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  tok_t [K-1:0]   in_t,
  output tok_t [K-1:0]   out_t
);
  localparam int H = K / 2;

  generate
    if (K == 2) begin : g_leaf
      cnet_balancer u_bal (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_a(in_t[0]), .in_b(in_t[1]),
        .out_hi(out_t[0]), .out_lo(out_t[1])
      );
    end else begin : g_split
      tok_t [K-1:0] mid;
      cnet_bitonic #(.K(H)) u_upper (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_t(in_t[H-1:0]), .out_t(mid[H-1:0])
      );
      cnet_bitonic #(.K(H)) u_lower (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_t(in_t[K-1:H]), .out_t(mid[K-1:H])
      );
      cnet_merger #(.K(K)) u_merge (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_t(mid), .out_t(out_t)
      );
    end
  endgenerate
endmodule

// File: rtl/cnet_wire_ctr.sv
module cnet_wire_ctr #(
  parameter int W     = 8,
  parameter int VAL_W = 16,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [VAL_W-1:0] value
);
  localparam logic [VAL_W-1:0] START  = VAL_W'(IDX);
  localparam logic [VAL_W-1:0] STRIDE = VAL_W'(W);

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= START;
    else if (take) value <= value + STRIDE;
  end
endmodule

// File: rtl/cnet_index_alloc.sv
module cnet_index_alloc
  import cnet_pkg::*;
#(
  parameter int W     = 8,
  parameter int VAL_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         req_valid,
  input  logic [W*TAG_W-1:0]   req_id,
  output logic                 req_ready,
  output logic [W-1:0]         rsp_valid,
  output logic [W*TAG_W-1:0]   rsp_id,
  output logic [W*VAL_W-1:0]   rsp_value,
  input  logic                 rsp_ready
);
  localparam int DEPTH = net_depth(W);
  localparam int IF_W  = $clog2(W * DEPTH + 1) + 1;
  localparam logic [VAL_W-1:0] STRIDE = VAL_W'(W);

  tok_t [W-1:0]     in_t, out_t;
  logic             adv;
  logic [VAL_W-1:0] ctr_val [W];

  assign adv       = rsp_ready || (rsp_valid == '0);
  assign req_ready = adv;

  generate
    for (genvar i = 0; i < W; i++) begin : g_port
      assign in_t[i].vld = req_valid[i];
      assign in_t[i].tag = req_id[i*TAG_W +: TAG_W];
      assign rsp_valid[i] = out_t[i].vld;
      assign rsp_id[i*TAG_W +: TAG_W] = out_t[i].tag;
      assign rsp_value[i*VAL_W +: VAL_W] = ctr_val[i];

      cnet_wire_ctr #(.W(W), .VAL_W(VAL_W), .IDX(i)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .take(out_t[i].vld && rsp_ready),
        .value(ctr_val[i])
      );

      // R4
      wire_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid[i] && rsp_ready) |=> (rsp_value[i*VAL_W +: VAL_W] == $past(rsp_value[i*VAL_W +: VAL_W]) + STRIDE))
        else $error("wire %0d index did not advance by the width", i);
    end
  endgenerate

  cnet_bitonic #(.K(W)) u_net (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_t(in_t), .out_t(out_t)
  );

  // tokens inside the network, kept for the quiescent check
  logic [IF_W-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight
                   + (adv ? IF_W'($countones(req_valid)) : IF_W'(0))
                   - (rsp_ready ? IF_W'($countones(rsp_valid)) : IF_W'(0));
  end

  logic             quiet_ok;
  logic [VAL_W-1:0] step_d, span_d;
  always_comb begin
    quiet_ok = 1'b1;
    for (int i = 1; i < W; i++) begin
      step_d = ctr_val[i] - ctr_val[i-1];
      if (!(step_d == VAL_W'(1) || step_d == VAL_W'(1 - W))) quiet_ok = 1'b0;
    end
    span_d = ctr_val[W-1] - ctr_val[0];
    if (!(span_d == VAL_W'(W - 1) || span_d == '1)) quiet_ok = 1'b0;
  end

  // R6
  always @(posedge clk) begin
    if (rst_n && inflight == '0) begin
      quiet_window_chk: assert (quiet_ok) else $error("step property broken while empty");
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_valid != '0) && !rsp_ready) |=> ($stable(rsp_valid) && $stable(rsp_id) && $stable(rsp_value)))
    else $error("response changed while stalled");
endmodule

// File: tb/tb_cnet_index_alloc.sv
module tb_cnet_index_alloc;
  localparam int W     = 8;
  localparam int TW    = cnet_pkg::TAG_W;
  localparam int VAL_W = 16;
  localparam int LG    = $clog2(W);
  localparam int D     = LG * (LG + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]       req_valid = '0;
  logic [W*TW-1:0]    req_id = '0;
  logic               req_ready;
  logic [W-1:0]       rsp_valid;
  logic [W*TW-1:0]    rsp_id;
  logic [W*VAL_W-1:0] rsp_value;
  logic               rsp_ready = 1'b0;

  always #4 clk = ~clk;

  cnet_index_alloc #(.W(W), .VAL_W(VAL_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_value(rsp_value), .rsp_ready(rsp_ready)
  );

  typedef struct { logic [W-1:0] m; logic [W*TW-1:0] ids; } grp_t;
  grp_t hq[$];
  bit   seen [0:65535];
  int   nextval [W];
  int   checks = 0, errors = 0;
  int   accepted = 0, issued = 0, last_val = -1;
  bit   last_adv;
  bit   prev_stall = 0;
  logic [W-1:0]       pv_valid;
  logic [W*TW-1:0]    pv_id;
  logic [W*VAL_W-1:0] pv_value;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one cycle: drive on the falling edge, sample one unit later
  task automatic step(input logic [W-1:0] v, input logic [W*TW-1:0] ids, input bit rr);
    int eb [16];
    int ab [16];
    bit exp_adv;
    bit bins_ok;
    grp_t g;
    @(negedge clk);
    req_valid = v; req_id = ids; rsp_ready = rr;
    #1;
    exp_adv = rr || (rsp_valid == '0);
    chk(req_ready == exp_adv, "R2 req_ready", req_ready, exp_adv);
    if (prev_stall) begin
      chk(rsp_valid == pv_valid && rsp_id == pv_id && rsp_value == pv_value,
          "R8 hold while stalled", rsp_value, pv_value);
    end
    g = hq[0];
    foreach (eb[t]) begin eb[t] = 0; ab[t] = 0; end
    for (int i = 0; i < W; i++) begin
      if (g.m[i]) eb[g.ids[i*TW +: TW]]++;
      if (rsp_valid[i]) ab[rsp_id[i*TW +: TW]]++;
    end
    chk($countones(rsp_valid) == $countones(g.m), "R3 token count", $countones(rsp_valid), $countones(g.m));
    bins_ok = 1;
    foreach (eb[t]) if (eb[t] != ab[t]) bins_ok = 0;
    chk(bins_ok, "R3 tag multiset", 0, 0);
    for (int i = 0; i < W; i++) begin
      if (rsp_valid[i]) begin
        int val;
        val = int'(rsp_value[i*VAL_W +: VAL_W]);
        chk(val % W == i, "R4 wire residue", val % W, i);
        chk(val == nextval[i], "R4 wire sequence", val, nextval[i]);
        chk(!seen[val], "R5 unique index", val, -1);
      end
    end
    prev_stall = (rsp_valid != '0) && !rr;
    pv_valid = rsp_valid; pv_id = rsp_id; pv_value = rsp_value;
    last_adv = exp_adv;
    if (exp_adv) begin
      g.m = v; g.ids = ids;
      hq.push_back(g);
      void'(hq.pop_front());
      accepted += $countones(v);
      if (rr) begin
        for (int i = 0; i < W; i++) begin
          if (rsp_valid[i]) begin
            int val;
            val = int'(rsp_value[i*VAL_W +: VAL_W]);
            seen[val] = 1;
            nextval[i] += W;
            issued++;
            last_val = val;
          end
        end
      end
    end
  endtask

  task automatic drain_and_check(input string tag);
    int gaps;
    for (int k = 0; k < D + 2; k++) step('0, '0, 1'b1);
    chk(issued == accepted, "R6 all tokens returned", issued, accepted);
    gaps = 0;
    for (int k = 0; k < issued; k++) if (!seen[k]) gaps++;
    chk(gaps == 0, {"R6 gap-free after ", tag}, gaps, 0);
  endtask

  task automatic random_phase(input int cycles, input int density, input int stall_pct);
    logic [W-1:0]    pend = '0;
    logic [W*TW-1:0] pid = '0;
    for (int c = 0; c < cycles; c++) begin
      bit rr;
      if (pend == '0) begin
        for (int i = 0; i < W; i++) pend[i] = (($urandom % 100) < density);
        pid = {$urandom, $urandom};
      end
      rr = (($urandom % 100) >= stall_pct);
      step(pend, pid, rr);
      if (last_adv) pend = '0;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", issued, accepted);
    summary();
  end

  initial begin
    grp_t empty;
    empty.m = '0; empty.ids = '0;
    for (int k = 0; k < D; k++) hq.push_back(empty);
    for (int i = 0; i < W; i++) nextval[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == '0, "R1 no response after reset", rsp_valid, 0);

    // one token at a time from several ports
    for (int k = 0; k < 2 * W; k++) begin
      int port;
      port = (k * 3 + 1) % W;
      step(W'(1) << port, W*TW'(k % 16) << (port * TW), 1'b1);
      for (int d = 0; d < D + 1; d++) step('0, '0, 1'b1);
      if (k == 0) chk(last_val == 0, "R1 first index from reset", last_val, 0);
      chk(last_val == k, "R7 sequential index", last_val, k);
    end
    drain_and_check("sequential");

    // every port every cycle, no stall
    random_phase(200, 100, 0);
    drain_and_check("full load");

    // sparse and dense bursts with back-pressure
    random_phase(3000, 30, 25);
    drain_and_check("sparse bursts");
    random_phase(3000, 80, 40);
    drain_and_check("dense bursts");
    random_phase(1000, 50, 80);
    drain_and_check("heavy stall");

    summary();
  end
endmodule